// File: doc/BRIEF.md
# Two-Wire Serial Command Front-End

This block is the slave side of a two-wire serial bus for a bank of digitally set wipers and their data registers. A fast system clock oversamples the SCL and SDA lines. The block finds start and stop conditions and checks the address byte. It then decodes the instruction byte that follows and hands a finished command to a register controller through a decoded command bus and single-cycle strobes. It never drives SDA high. It only asserts an active-high pull-low enable, which the pad turns into an open-drain output.

Most commands are two or three bytes long. The block issues a write or transfer command only when the stop condition arrives, so a frame cut short by a start or a stop leaves the register side untouched. For the two read instructions, the block asks the register side for a byte and shifts it out MSB first. The step instruction switches the bus into a bit-stream mode: each SCL high phase moves the selected wiper one step up or down, and this lasts until the stop. While the register side reports a nonvolatile write in progress, the block withholds the address acknowledge. A master can therefore poll for the end of the write by repeating start plus address.

Top module: `twowire_cmd_frontend`

## Requirements
- R1: After reset, sda_pull_o is 0, and no cmd_valid_o, rd_req_o, step_up_o or step_dn_o pulse occurs until a frame is received.
- R2: The block acknowledges the first byte after a start (pulls SDA low for the whole ninth SCL high phase) only when its upper nibble is 0101 and its lower nibble equals strap_i. On a mismatch it acknowledges nothing more until the next start.
- R3: While nv_busy_i is 1, a matching address gets no acknowledge. When nv_busy_i is 0, the same address is acknowledged.
- R4: The second byte is always acknowledged. It is split MSB first into opcode bits [7:4], register select bits [3:2] and wiper select bits [1:0], and these appear on cmd_op_o, cmd_reg_o and cmd_pot_o.
- R5: Opcodes 1101, 1110, 0001 and 1000 end after the second byte. A stop after that byte's acknowledge produces exactly one cmd_valid_o pulse, and no pulse occurs before the stop.
- R6: Opcodes 1010 and 1100 take a third byte, which is acknowledged and appears on cmd_data_o. A single cmd_valid_o pulse follows the stop.
- R7: Opcodes 1001 and 1011 give one rd_req_o pulse during the second byte's acknowledge. The block drives rd_data_i MSB first as the third byte (sampled when that acknowledge clock ends), then releases SDA for the master's acknowledge. These opcodes never produce cmd_valid_o.
- R8: After opcode 0010 is acknowledged, every complete SCL high phase gives one step pulse when SCL falls. The pulse is step_up_o if SDA was 1 at the rising edge and step_dn_o if it was 0. A stop ends the mode with no step and no cmd_valid_o.
- R9: A start or stop before a command's final acknowledge has completed, or a repeated start after it, discards the command (no cmd_valid_o). A repeated start begins a new address phase.
- R10: The second byte is acknowledged for every other opcode value too, and those values produce no strobe of any kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 4 | Board-strapped low address nibble |
| nv_busy_i | input | 1 | Register side is committing a nonvolatile write |
| rd_data_i | input | 8 | Byte to return for a read instruction |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| cmd_valid_o | output | 1 | One-cycle strobe: command complete at stop |
| cmd_op_o | output | 4 | Opcode of the current instruction |
| cmd_reg_o | output | 2 | Register select of the current instruction |
| cmd_pot_o | output | 2 | Wiper select of the current instruction |
| cmd_data_o | output | 8 | Data byte of a three-byte write |
| rd_req_o | output | 1 | One-cycle strobe: supply rd_data_i for the fields shown |
| step_up_o | output | 1 | One-cycle strobe: move wiper one step up |
| step_dn_o | output | 1 | One-cycle strobe: move wiper one step down |

## Verification
A wrong bit count or phase is visible on SDA within one byte: an acknowledge shows up on the wrong ninth clock or is missing, or a read byte comes out shifted by one position. A wrong opcode class shows up at the stop, either as a missing or extra cmd_valid_o, or as a step strobe where none was due. A stale pending flag after an abort shows up as a command strobe at the stop of a frame that was cut short. The bench sweeps every strap value against matching and mismatching addresses and every opcode value. It checks each strobe count and field value shortly after the stop or the byte that should cause it.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
  localparam int BYTE_W  = 8;
  localparam int OP_W    = 4;
  localparam int SEL_W   = 2;
  localparam int TYPE_W  = 4;
  localparam int STRAP_W = BYTE_W - TYPE_W;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_INSTR, PH_WDATA, PH_RDATA, PH_STEP, PH_HOLD
  } phase_t;

  localparam logic [OP_W-1:0] OP_STEP       = 4'b0010;
  localparam logic [OP_W-1:0] OP_RD_WIPER   = 4'b1001;
  localparam logic [OP_W-1:0] OP_WR_WIPER   = 4'b1010;
  localparam logic [OP_W-1:0] OP_RD_REG     = 4'b1011;
  localparam logic [OP_W-1:0] OP_WR_REG     = 4'b1100;
  localparam logic [OP_W-1:0] OP_REG2WIPER  = 4'b1101;
  localparam logic [OP_W-1:0] OP_WIPER2REG  = 4'b1110;
  localparam logic [OP_W-1:0] OP_ALL_R2W    = 4'b0001;
  localparam logic [OP_W-1:0] OP_ALL_W2R    = 4'b1000;

  function automatic logic op_is_short(input logic [OP_W-1:0] op);
    return (op == OP_REG2WIPER) || (op == OP_WIPER2REG) ||
           (op == OP_ALL_R2W)   || (op == OP_ALL_W2R);
  endfunction

  function automatic logic op_is_write3(input logic [OP_W-1:0] op);
    return (op == OP_WR_WIPER) || (op == OP_WR_REG);
  endfunction

  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return (op == OP_RD_WIPER) || (op == OP_RD_REG);
  endfunction
endpackage

// File: rtl/tw_line_sync.sv
`timescale 1ns/1ps
module tw_line_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [STAGES-1:0][WIDTH-1:0] stg;
  logic [WIDTH-1:0]             prev;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= {stg[STAGES-2:0], din};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stg <= RST_VAL;
        else     stg <= din;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= stg[STAGES-1];
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/tw_slave_fsm.sv
`timescale 1ns/1ps
module tw_slave_fsm
  import tw_pkg::*;
#(
  parameter logic [TYPE_W-1:0] TYPE_ID = 4'b0101
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_lvl,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic [STRAP_W-1:0] strap,
  input  logic               nv_busy,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               sda_pull,
  output logic               cmd_valid,
  output logic [OP_W-1:0]    cmd_op,
  output logic [SEL_W-1:0]   cmd_reg,
  output logic [SEL_W-1:0]   cmd_pot,
  output logic [BYTE_W-1:0]  cmd_data,
  output logic               rd_req,
  output logic               step_up,
  output logic               step_dn
);
  localparam int                CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  phase_t              phase;
  logic [CNT_W-1:0]    cnt;
  logic                seen_rise;
  logic                pending;
  logic                step_dir;
  logic [BYTE_W-1:0]   rx_sh;
  logic [BYTE_W-2:0]   tx_sh;
  logic                addr_hit;

  assign addr_hit = (rx_sh == {TYPE_ID, strap});

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      seen_rise <= 1'b0;
      pending   <= 1'b0;
      step_dir  <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      sda_pull  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_reg   <= '0;
      cmd_pot   <= '0;
      cmd_data  <= '0;
      rd_req    <= 1'b0;
      step_up   <= 1'b0;
      step_dn   <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      rd_req    <= 1'b0;
      step_up   <= 1'b0;
      step_dn   <= 1'b0;
      if (start_evt) begin
        phase     <= PH_ADDR;
        cnt       <= '0;
        seen_rise <= 1'b0;
        pending   <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (stop_evt) begin
        if (phase == PH_HOLD && pending) cmd_valid <= 1'b1;
        phase     <= PH_IDLE;
        seen_rise <= 1'b0;
        pending   <= 1'b0;
        sda_pull  <= 1'b0;
      end else if (scl_rise && phase != PH_IDLE) begin
        seen_rise <= 1'b1;
        step_dir  <= sda_lvl;
        if (cnt < ACK_SLOT) rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
      end else if (scl_fall && seen_rise) begin
        seen_rise <= 1'b0;
        unique case (phase)
          PH_ADDR, PH_INSTR, PH_WDATA: begin
            if (cnt < LAST_BIT) begin
              cnt <= cnt + 1'b1;
            end else if (cnt == LAST_BIT) begin
              cnt <= ACK_SLOT;
              if (phase == PH_ADDR) begin
                if (addr_hit && !nv_busy) sda_pull <= 1'b1;
                else                      phase    <= PH_IDLE;
              end else if (phase == PH_INSTR) begin
                sda_pull <= 1'b1;
                cmd_op   <= rx_sh[BYTE_W-1 -: OP_W];
                cmd_reg  <= rx_sh[2*SEL_W-1 -: SEL_W];
                cmd_pot  <= rx_sh[SEL_W-1:0];
                if (op_is_read(rx_sh[BYTE_W-1 -: OP_W])) rd_req <= 1'b1;
              end else begin
                sda_pull <= 1'b1;
                cmd_data <= rx_sh;
              end
            end else begin
              cnt      <= '0;
              sda_pull <= 1'b0;
              if (phase == PH_ADDR) begin
                phase <= PH_INSTR;
              end else if (phase == PH_INSTR) begin
                if (op_is_read(cmd_op)) begin
                  phase    <= PH_RDATA;
                  tx_sh    <= rd_data[BYTE_W-2:0];
                  sda_pull <= ~rd_data[BYTE_W-1];
                end else if (cmd_op == OP_STEP) begin
                  phase <= PH_STEP;
                end else if (op_is_write3(cmd_op)) begin
                  phase <= PH_WDATA;
                end else begin
                  phase   <= PH_HOLD;
                  pending <= op_is_short(cmd_op);
                end
              end else begin
                phase   <= PH_HOLD;
                pending <= 1'b1;
              end
            end
          end
          PH_RDATA: begin
            if (cnt < LAST_BIT) begin
              tx_sh    <= {tx_sh[BYTE_W-3:0], 1'b0};
              sda_pull <= ~tx_sh[BYTE_W-2];
              cnt      <= cnt + 1'b1;
            end else if (cnt == LAST_BIT) begin
              sda_pull <= 1'b0;
              cnt      <= ACK_SLOT;
            end else begin
              phase <= PH_HOLD;
              cnt   <= '0;
            end
          end
          PH_STEP: begin
            if (step_dir) step_up <= 1'b1;
            else          step_dn <= 1'b1;
          end
          default: begin
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/twowire_cmd_frontend.sv
`timescale 1ns/1ps
module twowire_cmd_frontend
  import tw_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [TYPE_W-1:0] TYPE_ID     = 4'b0101
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               nv_busy_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_pull_o,
  output logic               cmd_valid_o,
  output logic [OP_W-1:0]    cmd_op_o,
  output logic [SEL_W-1:0]   cmd_reg_o,
  output logic [SEL_W-1:0]   cmd_pot_o,
  output logic [BYTE_W-1:0]  cmd_data_o,
  output logic               rd_req_o,
  output logic               step_up_o,
  output logic               step_dn_o
);
  logic [1:0] line_lvl, line_rise, line_fall;
  logic       start_evt, stop_evt;

  tw_line_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) i_sync (
    .clk (clk),
    .rst (rst),
    .din ({scl_i, sda_i}),
    .lvl (line_lvl),
    .rise(line_rise),
    .fall(line_fall)
  );

  assign start_evt = line_fall[0] & line_lvl[1];
  assign stop_evt  = line_rise[0] & line_lvl[1];

  tw_slave_fsm #(
    .TYPE_ID(TYPE_ID)
  ) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (line_rise[1]),
    .scl_fall (line_fall[1]),
    .sda_lvl  (line_lvl[0]),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .strap    (strap_i),
    .nv_busy  (nv_busy_i),
    .rd_data  (rd_data_i),
    .sda_pull (sda_pull_o),
    .cmd_valid(cmd_valid_o),
    .cmd_op   (cmd_op_o),
    .cmd_reg  (cmd_reg_o),
    .cmd_pot  (cmd_pot_o),
    .cmd_data (cmd_data_o),
    .rd_req   (rd_req_o),
    .step_up  (step_up_o),
    .step_dn  (step_dn_o)
  );
endmodule

// File: rtl/twowire_cmd_frontend_chk.sv
`timescale 1ns/1ps
module twowire_cmd_frontend_chk
  import tw_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            scl_i,
  input logic            sda_pull_o,
  input logic            cmd_valid_o,
  input logic [OP_W-1:0] cmd_op_o,
  input logic            rd_req_o,
  input logic            step_up_o,
  input logic            step_dn_o,
  input logic            stop_evt
);
  // R2: the pull-low enable only turns on while the bus clock is low
  a_r2_pull_rises_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_i);

  // R5: command strobe follows a stop condition by one cycle
  a_r5_cmd_after_stop: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> $past(stop_evt));

  // R10: only short or write opcodes ever produce a command strobe
  a_r10_cmd_known_op: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> (op_is_short(cmd_op_o) || op_is_write3(cmd_op_o)));

  // R7: read request only for the read opcodes
  a_r7_rdreq_read_op: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> op_is_read(cmd_op_o));

  // R8: steps only under the step opcode, single-cycle pulses
  a_r8_step_op: assert property (@(posedge clk) disable iff (rst)
    (step_up_o || step_dn_o) |-> (cmd_op_o == OP_STEP));

  a_r8_step_pulse: assert property (@(posedge clk) disable iff (rst)
    (step_up_o || step_dn_o) |=> !(step_up_o || step_dn_o));
endmodule

bind twowire_cmd_frontend twowire_cmd_frontend_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .sda_pull_o (sda_pull_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_op_o   (cmd_op_o),
  .rd_req_o   (rd_req_o),
  .step_up_o  (step_up_o),
  .step_dn_o  (step_dn_o),
  .stop_evt   (stop_evt)
);

// File: tb/test_twowire_cmd_frontend.sv
`timescale 1ns/1ps
module test_twowire_cmd_frontend;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [3:0] strap = 4'hA;
  logic       nv_busy = 1'b0;
  logic [7:0] rd_data;
  logic       sda_pull, cmd_valid, rd_req, step_up, step_dn;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_pot;
  logic [7:0] cmd_data;
  wire        sda_bus = sda_m & ~sda_pull;

  int total = 0;
  int bad   = 0;
  int n_cmd = 0, n_rd = 0, n_up = 0, n_dn = 0;
  logic [3:0] cap_op;
  logic [1:0] cap_reg, cap_pot;
  logic [7:0] cap_data;

  always #2 clk = ~clk;

  function automatic logic [7:0] rd_model(input logic [3:0] op, input logic [1:0] r, input logic [1:0] p);
    if (op == 4'b1001) return 8'h96 + 8'(p) * 8'd29;
    return {r, p, 4'h0} ^ 8'h4B;
  endfunction

  assign rd_data = rd_model(cmd_op, cmd_reg, cmd_pot);

  twowire_cmd_frontend i_twowire_cmd_frontend (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
    .nv_busy_i(nv_busy), .rd_data_i(rd_data), .sda_pull_o(sda_pull),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_reg_o(cmd_reg),
    .cmd_pot_o(cmd_pot), .cmd_data_o(cmd_data), .rd_req_o(rd_req),
    .step_up_o(step_up), .step_dn_o(step_dn)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_cmd++; cap_op = cmd_op; cap_reg = cmd_reg; cap_pot = cmd_pot; cap_data = cmd_data;
    end
    if (rd_req)  n_rd++;
    if (step_up) n_up++;
    if (step_dn) n_dn++;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = !sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic get_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); b[i] = sda_bus; wq(); scl = 1'b0; wq();
    end
    put_bit(1'b1);
  endtask

  task automatic head(input logic [7:0] instr, output logic a_ack, output logic i_ack);
    bus_start();
    put_byte({4'b0101, strap}, a_ack);
    put_byte(instr, i_ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a, b, c;
    logic [7:0] rb;
    int n0, u0, d0, r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    // R1: quiet after reset
    check("R1 pull", int'(sda_pull), 0);
    check("R1 strobes", n_cmd + n_rd + n_up + n_dn, 0);

    // R2: every strap value, match and mismatch
    for (int s = 0; s < 16; s++) begin
      strap = 4'(s);
      bus_start(); put_byte({4'b0101, 4'(s)}, a); bus_stop();
      check("R2 match ack", int'(a), 1);
      bus_start(); put_byte({4'b0101, 4'(s) ^ 4'h5}, a); put_byte(8'hD0, b); bus_stop();
      check("R2 strap miss", int'(a), 0);
      check("R2 silent after miss", int'(b), 0);
      bus_start(); put_byte({4'b0111, 4'(s)}, a); bus_stop();
      check("R2 type miss", int'(a), 0);
    end
    check("R2 no cmd", n_cmd, 0);

    // R3: busy polling
    strap = 4'h6; nv_busy = 1'b1;
    bus_start(); put_byte(8'h56, a); bus_stop();
    check("R3 busy no ack", int'(a), 0);
    nv_busy = 1'b0;
    bus_start(); put_byte(8'h56, a); bus_stop();
    check("R3 idle ack", int'(a), 1);

    // R4 / R5: short commands
    for (int k = 0; k < 4; k++) begin
      for (int rp = 0; rp < 16; rp += 5) begin
        logic [3:0] op;
        op = (k == 0) ? 4'b1101 : (k == 1) ? 4'b1110 : (k == 2) ? 4'b0001 : 4'b1000;
        n0 = n_cmd;
        head({op, 4'(rp)}, a, b);
        check("R4 instr ack", int'(b), 1);
        check("R5 no cmd before stop", n_cmd - n0, 0);
        bus_stop();
        check("R5 one cmd", n_cmd - n0, 1);
        check("R4 op", int'(cap_op), int'(op));
        check("R4 reg", int'(cap_reg), rp / 4);
        check("R4 pot", int'(cap_pot), rp % 4);
      end
    end

    // R6: three-byte writes
    n0 = n_cmd;
    head(8'b1010_0011, a, b); put_byte(8'h5C, c);
    check("R6 data ack", int'(c), 1);
    check("R6 no cmd before stop", n_cmd - n0, 0);
    bus_stop();
    check("R6 one cmd", n_cmd - n0, 1);
    check("R6 op", int'(cap_op), 10);
    check("R6 data", int'(cap_data), 8'h5C);
    n0 = n_cmd;
    head(8'b1100_1001, a, b); put_byte(8'hE3, c); bus_stop();
    check("R6 data ack 2", int'(c), 1);
    check("R6 one cmd 2", n_cmd - n0, 1);
    check("R6 data 2", int'(cap_data), 8'hE3);
    check("R6 reg", int'(cap_reg), 2);
    check("R6 pot", int'(cap_pot), 1);

    // R7: reads
    for (int k = 0; k < 2; k++) begin
      logic [7:0] ins;
      ins = (k == 0) ? 8'b1001_0010 : 8'b1011_1101;
      n0 = n_cmd; r0 = n_rd;
      head(ins, a, b);
      check("R7 instr ack", int'(b), 1);
      check("R7 rd_req", n_rd - r0, 1);
      get_byte(rb);
      check("R7 released", int'(sda_pull), 0);
      bus_stop();
      check("R7 byte", int'(rb), int'(rd_model(ins[7:4], ins[3:2], ins[1:0])));
      check("R7 no cmd", n_cmd - n0, 0);
    end

    // R8: step stream 1101_0110 -> 5 up, 3 down
    n0 = n_cmd; u0 = n_up; d0 = n_dn;
    head(8'b0010_0011, a, b);
    check("R8 instr ack", int'(b), 1);
    begin
      logic [7:0] pat;
      pat = 8'b1101_0110;
      for (int i = 7; i >= 0; i--) put_bit(pat[i]);
    end
    bus_stop();
    check("R8 ups", n_up - u0, 5);
    check("R8 downs", n_dn - d0, 3);
    check("R8 no cmd", n_cmd - n0, 0);

    // R9: aborts
    n0 = n_cmd;
    head(8'b1010_0001, a, b);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_start(); put_byte({4'b0101, strap}, a);
    check("R9 restart ack", int'(a), 1);
    bus_stop();
    check("R9 mid data abort", n_cmd - n0, 0);
    bus_start(); put_byte({4'b0101, strap}, a);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    check("R9 mid instr abort", n_cmd - n0, 0);
    head(8'b1101_0000, a, b); bus_start(); bus_stop();
    check("R9 repeated start drop", n_cmd - n0, 0);
    head(8'b1110_0110, a, b); bus_stop();
    check("R9 recovery", n_cmd - n0, 1);

    // R10: every opcode value without a payload
    for (int op = 0; op < 16; op++) begin
      if (op == 9 || op == 11) continue;
      n0 = n_cmd; u0 = n_up; d0 = n_dn; r0 = n_rd;
      head({4'(op), 4'b0110}, a, b);
      bus_stop();
      check("R10 ack", int'(b), 1);
      check("R10 cmd count", n_cmd - n0,
            (op == 13 || op == 14 || op == 1 || op == 8) ? 1 : 0);
      check("R10 other strobes", (n_up - u0) + (n_dn - d0) + (n_rd - r0), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule